// File: doc/BRIEF.md
# Pipelined CORDIC Vector Magnitude

This block turns a stream of signed two-component vectors into their Euclidean length, sqrt(x^2 + y^2), using only shifts, additions and subtractions. Each sample is first moved into the half-plane y >= 0 by negating both components when y is negative. It is then scaled up by 2^FRAC_SH to keep fractional precision, and multiplied by the shift-add constant 1 + 1/4 - 1/32 - 1/256 (about 1.2148). That constant cancels most of the CORDIC gain, so the overall gain lands close to 2. A chain of STAGES vectoring micro-rotations follows, one per register stage. Rotation i looks at the sign of x and moves the vector towards x = 0, using shift i on both cross terms. The magnitude is read from the final y component, shifted right by FRAC_SH + 1.

The block takes one sample per clock with no back-pressure. A valid flag travels next to the data. The raw x and y inputs travel through a delay line of the same depth, so each magnitude leaves the block together with the vector it was computed from. Use it after a complex mixer or a quadrature filter to get an envelope, or anywhere a cheap amplitude estimate is needed.

Top module: `cordic_mag`

## Requirements
- R1: For every accepted vector, mag_o differs from the exact sqrt(x^2+y^2) by no more than (exact/64 + 2) LSB, with no external gain correction.
- R2: For an input with y < 0, mag_o is bit-identical to the result for the input (-x, -y), because negative-y vectors are folded by negating both components.
- R3: Full-scale inputs, including x or y equal to -2^(IN_W-1) and all four corners of the input square, give results within the R1 bound and a non-negative internal final y (no datapath overflow).
- R4: The vector (0, 0) gives mag_o = 0 exactly.
- R5: out_valid_o is high exactly STAGES + 2 clock cycles after each cycle in which in_valid_i is sampled high, once per accepted sample.
- R6: When out_valid_o is high, x_o and y_o equal the x_i and y_i values of the same sample (two's complement, IN_W bits).
- R7: While rst_ni is low and directly after reset, out_valid_o, x_o, y_o and mag_o are all zero.
- R8: A cycle with in_valid_i low yields no out_valid_o pulse, and consecutive valid samples in back-to-back cycles are each computed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample on x_i / y_i is accepted this cycle |
| x_i | input | IN_W | Signed x component |
| y_i | input | IN_W | Signed y component |
| out_valid_o | output | 1 | mag_o, x_o and y_o carry a result |
| x_o | output | IN_W | x_i of the sample, delayed to match the result |
| y_o | output | IN_W | y_i of the sample, delayed to match the result |
| mag_o | output | IN_W+1 | Unsigned magnitude estimate |

## Verification
The bench builds the block with IN_W = 16, STAGES = 5 and FRAC_SH = 4, which gives a latency of 7 cycles and a datapath of 25 bits. These values bring the five-rotation accuracy limit within reach: a radius-20000 sweep and a radius-300 sweep around the full circle show the residual-angle error and the truncation error. They also put the most negative 16-bit code at the corners of the input square, where the fold negation and the gain of about 2.8 on the diagonal push the internal width hardest. Mirrored input pairs check that folding gives bit-exact agreement, and bubbles between samples check that valid flags stay aligned with the data.

// File: rtl/cmag_pkg.sv
package cmag_pkg;
  // guard bits: fold sign growth, prescale gain, CORDIC growth, sqrt(2) corner, sign
  localparam int unsigned CMAG_GUARD = 5;

  function automatic int unsigned cmag_dp_width(input int unsigned in_w, input int unsigned frac_sh);
    return in_w + frac_sh + CMAG_GUARD;
  endfunction

  // fold stage + prescale stage + one per rotation
  function automatic int unsigned cmag_latency(input int unsigned stages);
    return stages + 2;
  endfunction
endpackage

// File: rtl/cmag_fold_scale.sv
module cmag_fold_scale #(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned FRAC_SH = 4,
  parameter int unsigned W       = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IN_W-1:0]     x_i,
  input  logic [IN_W-1:0]     y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] x_ext, y_ext, x_sc, y_sc, x_nx, y_nx;

  always_comb begin
    x_ext = {{(W-IN_W){x_i[IN_W-1]}}, x_i};
    y_ext = {{(W-IN_W){y_i[IN_W-1]}}, y_i};
    x_sc  = x_ext <<< FRAC_SH;
    y_sc  = y_ext <<< FRAC_SH;
    if (y_i[IN_W-1]) begin
      x_nx = -x_sc;
      y_nx = -y_sc;
    end else begin
      x_nx = x_sc;
      y_nx = y_sc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else begin
      x_o <= x_nx;
      y_o <= y_nx;
    end
  end
endmodule

// File: rtl/cmag_prescale.sv
module cmag_prescale #(
  parameter int unsigned W = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  // v * (1 + 1/4 - 1/32 - 1/256): trims the rotation gain to about 2
  function automatic logic signed [W-1:0] trim(input logic signed [W-1:0] v);
    return v + (v >>> 2) - (v >>> 5) - (v >>> 8);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else begin
      x_o <= trim(x_i);
      y_o <= trim(y_i);
    end
  end
endmodule

// File: rtl/cmag_rotate.sv
module cmag_rotate #(
  parameter int unsigned W     = 25,
  parameter int unsigned SHIFT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] x_sh, y_sh;
  logic                x_pos;

  assign x_sh  = x_i >>> SHIFT;
  assign y_sh  = y_i >>> SHIFT;
  assign x_pos = !x_i[W-1] && (x_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= '0;
      y_o <= '0;
    end else if (x_pos) begin
      x_o <= x_i - y_sh;
      y_o <= y_i + x_sh;
    end else begin
      x_o <= x_i + y_sh;
      y_o <= y_i - x_sh;
    end
  end
endmodule

// File: rtl/cmag_delay.sv
module cmag_delay #(
  parameter int unsigned WIDTH = 33,
  parameter int unsigned DEPTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[s] <= '0;
      else if (s == 0) pipe[s] <= d_i;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/cordic_mag.sv
module cordic_mag
  import cmag_pkg::*;
#(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned STAGES  = 5,
  parameter int unsigned FRAC_SH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [IN_W-1:0] x_i,
  input  logic [IN_W-1:0] y_i,
  output logic            out_valid_o,
  output logic [IN_W-1:0] x_o,
  output logic [IN_W-1:0] y_o,
  output logic [IN_W:0]   mag_o
);
  localparam int unsigned W     = cmag_dp_width(IN_W, FRAC_SH);
  localparam int unsigned LAT   = cmag_latency(STAGES);
  localparam int unsigned MAG_W = IN_W + 1;
  localparam int unsigned SB_W  = 2*IN_W + 1;

  logic signed [W-1:0] fold_x, fold_y, pre_x, pre_y;
  logic signed [W-1:0] rot_x [STAGES+1];
  logic signed [W-1:0] rot_y [STAGES+1];
  logic signed [W-1:0] y_last, y_scaled;
  logic [SB_W-1:0]     side_d, side_q;
  logic                unused_bits;

  cmag_fold_scale #(.IN_W(IN_W), .FRAC_SH(FRAC_SH), .W(W)) i_fold (
    .clk_i, .rst_ni, .x_i, .y_i, .x_o(fold_x), .y_o(fold_y)
  );

  cmag_prescale #(.W(W)) i_pre (
    .clk_i, .rst_ni, .x_i(fold_x), .y_i(fold_y), .x_o(pre_x), .y_o(pre_y)
  );

  assign rot_x[0] = pre_x;
  assign rot_y[0] = pre_y;

  for (genvar s = 0; s < STAGES; s++) begin : g_rot
    cmag_rotate #(.W(W), .SHIFT(s)) i_rot (
      .clk_i, .rst_ni,
      .x_i(rot_x[s]),   .y_i(rot_y[s]),
      .x_o(rot_x[s+1]), .y_o(rot_y[s+1])
    );
  end

  // gain ~2 and fixed-point scale removed by one arithmetic shift
  assign y_last   = rot_y[STAGES];
  assign y_scaled = y_last >>> (FRAC_SH + 1);
  assign mag_o    = y_last[W-1] ? '0 : y_scaled[MAG_W-1:0];

  assign side_d = {in_valid_i, x_i, y_i};

  cmag_delay #(.WIDTH(SB_W), .DEPTH(LAT)) i_side (
    .clk_i, .rst_ni, .d_i(side_d), .q_o(side_q)
  );

  assign out_valid_o = side_q[SB_W-1];
  assign x_o         = side_q[2*IN_W-1:IN_W];
  assign y_o         = side_q[IN_W-1:0];

  assign unused_bits = ^{rot_x[STAGES], y_scaled[W-1:MAG_W]};
endmodule

// File: rtl/cmag_checker.sv
module cmag_checker #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned LAT  = 7,
  parameter int unsigned W    = 25
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                out_valid_o,
  input logic [IN_W-1:0]     x_o,
  input logic [IN_W-1:0]     y_o,
  input logic [IN_W:0]       mag_o,
  input logic signed [W-1:0] fold_y,
  input logic signed [W-1:0] y_last
);
  int ax, ay, amax, asum, mg;
  int unsigned pending;

  always_comb begin
    ax   = int'($signed(x_o));
    ay   = int'($signed(y_o));
    ax   = (ax < 0) ? -ax : ax;
    ay   = (ay < 0) ? -ay : ay;
    amax = (ax > ay) ? ax : ay;
    asum = ax + ay;
    mg   = int'(mag_o);
  end

  // samples accepted and not yet delivered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending <= 0;
    else pending <= pending + (in_valid_i ? 1 : 0) - (out_valid_o ? 1 : 0);
  end

  AST_MAG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (64*mg + 128 >= 63*amax) && (64*mg <= 65*asum + 128)); // R1

  AST_FOLD_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fold_y[W-1]); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !y_last[W-1]); // R3

  AST_ZERO_MAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && x_o == '0 && y_o == '0) |-> mg == 0); // R4

  AST_FULL_PIPE_EMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending == LAT) |-> out_valid_o); // R5

  AST_PENDING_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending <= LAT); // R5

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pending != 0); // R8
endmodule

bind cordic_mag cmag_checker #(.IN_W(IN_W), .LAT(LAT), .W(W)) i_cmag_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .out_valid_o(out_valid_o),
  .x_o(x_o), .y_o(y_o), .mag_o(mag_o), .fold_y(fold_y), .y_last(y_last)
);

// File: tb/test_cordic_mag.sv
module test_cordic_mag;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 16;
  localparam int STAGES = 5;
  localparam int LAT    = STAGES + 2;
  localparam real PI    = 3.14159265358979;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [IN_W-1:0] x_in = '0, y_in = '0;
  logic            out_valid;
  logic [IN_W-1:0] x_out, y_out;
  logic [IN_W:0]   mag;

  cordic_mag #(.IN_W(IN_W), .STAGES(STAGES), .FRAC_SH(4)) i_cordic_mag (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .x_i(x_in), .y_i(y_in),
    .out_valid_o(out_valid), .x_o(x_out), .y_o(y_out), .mag_o(mag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int x; int y; int cyc; bit mirror; string tag;} item_t;
  item_t sb_q[$];
  int cyc = 0;
  int n_checks = 0, n_errors = 0;
  int prev_mag = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int x, input int y, input bit mirror, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    x_in = x[IN_W-1:0];
    y_in = y[IN_W-1:0];
    sb_q.push_back('{x, y, cyc, mirror, tag});
  endtask

  task automatic bubble();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 spurious out_valid", 1, 0);
      end else begin
        item_t it;
        real ref_v, err;
        int m;
        it = sb_q.pop_front();
        m = int'(mag);
        chk(cyc - it.cyc == LAT, "R5 latency", cyc - it.cyc, LAT);
        chk(int'($signed(x_out)) == it.x, "R6 x_o alignment", int'($signed(x_out)), it.x);
        chk(int'($signed(y_out)) == it.y, "R6 y_o alignment", int'($signed(y_out)), it.y);
        ref_v = $sqrt(real'(it.x)*real'(it.x) + real'(it.y)*real'(it.y));
        err = real'(m) - ref_v;
        if (err < 0.0) err = -err;
        chk(err <= ref_v/64.0 + 2.0, {it.tag, " magnitude bound"}, m, $rtoi(ref_v + 0.5));
        if (it.tag == "R4") chk(m == 0, "R4 zero vector", m, 0);
        if (it.mirror) chk(m == prev_mag, "R2 fold mirror equality", m, prev_mag);
        prev_mag = m;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    int px, py;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    chk(x_out == '0, "R7 x_o in reset", int'(x_out), 0);
    chk(y_out == '0, "R7 y_o in reset", int'(y_out), 0);
    chk(mag == '0, "R7 mag_o in reset", int'(mag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && mag == '0, "R7 state after reset", int'(mag), 0);

    drive(0, 0, 1'b0, "R4");
    bubble();

    // R1: large radius sweep, back-to-back (R8)
    for (int k = 0; k < 64; k++) begin
      real a = 2.0*PI*real'(k)/64.0;
      drive($rtoi(20000.0*$cos(a)), $rtoi(20000.0*$sin(a)), 1'b0, "R1");
    end
    // R1 / R8: small radius with bubbles
    for (int k = 0; k < 32; k++) begin
      real a = 2.0*PI*real'(k)/32.0 + 0.05;
      drive($rtoi(300.0*$cos(a)), $rtoi(300.0*$sin(a)), 1'b0, "R1");
      bubble();
      if (k % 3 == 0) bubble();
    end

    // R3: full-scale corners and axes
    drive(-32768, -32768, 1'b0, "R3");
    drive( 32767,  32767, 1'b0, "R3");
    drive(-32768,  32767, 1'b0, "R3");
    drive( 32767, -32768, 1'b0, "R3");
    drive(-32768,      0, 1'b0, "R3");
    drive(     0, -32768, 1'b0, "R3");
    drive( 32767,      0, 1'b0, "R3");
    drive(     0,  32767, 1'b0, "R3");
    drive(     1,      0, 1'b0, "R3");

    // R2: mirrored pairs, second of each has y < 0
    drive( 1234,  5678, 1'b0, "R2");
    drive(-1234, -5678, 1'b1, "R2");
    drive(-20000,   17, 1'b0, "R2");
    drive( 20000,  -17, 1'b1, "R2");
    drive(  -5,      3, 1'b0, "R2");
    drive(   5,     -3, 1'b1, "R2");
    drive(32767, 32767, 1'b0, "R2");
    drive(-32767, -32767, 1'b1, "R2");

    // R8: pseudo-random stream
    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 200; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      px = int'($signed(lfsr[15:0]));
      py = int'($signed(lfsr[31:16]));
      drive(px, py, 1'b0, "R8");
      if (lfsr[3:0] == 4'd0) bubble();
    end

    bubble();
    repeat (LAT + 6) @(negedge clk);
    chk(sb_q.size() == 0, "R5 all samples delivered", sb_q.size(), 0);
    chk(out_valid == 1'b0, "R8 idle after drain", int'(out_valid), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule